// File: doc/BRIEF.md
# Lockable Secure Monotonic Counter

This block holds a counter that software can only move forward, together with a small bank of retained general-purpose words. It is reached through a plain word-addressed register port: one write strobe, one read strobe, a word address and 32-bit data. The count is 48 bits wide by default. Its lower 32 bits form the low word. Its upper bits sit at the bottom of the high word, and the top half of the high word holds a 16-bit era tag that is separate from the count. Software cannot load the count. The only way to change it is to step it by one, and any write to the low word is such a request.

Stepping is accepted only while a set-only enable-and-valid bit is on and the counter is unlocked. Two lock levels protect the counter, and a second pair of locks protects the retained words. A soft lock stays set until the software reset input or the power-on reset. A hard lock stays set until the power-on reset. If the count wraps past its all-ones value, the block raises a sticky rollover flag and drops the enable bit for good. Each retained word can be reached at two addresses: the primary window at 0xC..0xF and the alias window at 0x8..0xB, with word n at offset n in both.

Top module: `mono_ctr_vault`

## Requirements
- R1: After power-on reset (`rst`), every readable location returns 0: locks, control, status, both counter words and all retained words.
- R2: A write to word 0x5 (low word) while the enable bit is 1 and the counter is unlocked adds exactly 1 to the count, whatever the write data. The carry from the low part appears in bits 15:0 of word 0x4 (high word).
- R3: A write to word 0x5 while the enable bit (bit 2 of word 0x2) is 0 leaves the count unchanged.
- R4: The counter soft lock (bit 4 of word 0x0) and the counter hard lock (bit 4 of word 0x1) each block three things: increments, era writes and setting the enable bit.
- R5: The retained-word soft lock (bit 5 of word 0x0) and hard lock (bit 5 of word 0x1) each block writes to the retained words. Reads of those words still return their contents.
- R6: A pulse on `soft_rst` clears both soft-lock bits. It leaves the hard locks, the count, the era and the retained words unchanged.
- R7: Lock bits are write-1-to-set, and writing 0 to a lock bit has no effect. Hard-lock bits are cleared only by `rst`.
- R8: A write to word 0x4 loads bits 31:16 as the era while the counter is unlocked. Bits 15:0 of that write are ignored.
- R9: An increment from the all-ones count wraps the count to 0, sets the rollover flag (bit 2 of word 0x3) and clears the enable bit. After that, increments are ignored and the enable bit cannot be set again until `rst`.
- R10: Retained word n (n = 0..3) is the same storage at word address 0xC+n and at word address 0x8+n.
- R11: Read data is registered: `rdata` shows the addressed word on the cycle after `rd_en`, and it returns 0 for unmapped addresses (0x6, 0x7).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset, clears all state |
| soft_rst | input | 1 | Synchronous active-high software reset, clears soft locks only |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 4 | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |

## Verification
The hardest state to reach from the ports is rollover. At the default width it would take 2^48 increments. The bench therefore drives a second instance with a 6-bit count (4-bit low part) on the same bus. Sixty-four low-word writes carry that instance through the low-to-high carry and on into the wrap. After the wrap the bench checks that the flag sets, the enable bit drops and later enable writes are refused, while the full-width instance on the same stimulus simply reads 64.

// File: rtl/mcv_pkg.sv
package mcv_pkg;
  localparam int DATA_W = 32;
  localparam int ERA_W  = 16;

  // word addresses of the register map
  localparam logic [3:0] A_SOFTLOCK = 4'h0;
  localparam logic [3:0] A_HARDLOCK = 4'h1;
  localparam logic [3:0] A_CTRL     = 4'h2;
  localparam logic [3:0] A_STATUS   = 4'h3;
  localparam logic [3:0] A_CNT_HI   = 4'h4;
  localparam logic [3:0] A_CNT_LO   = 4'h5;
  localparam logic [1:0] GPR_ALIAS  = 2'b10;  // 0x8..0xB
  localparam logic [1:0] GPR_PRIME  = 2'b11;  // 0xC..0xF

  // bit positions software depends on
  localparam int B_CNT_LOCK = 4;
  localparam int B_GPR_LOCK = 5;
  localparam int B_ENABLE   = 2;
  localparam int B_ROLLOVER = 2;

  typedef struct packed {
    logic gpr;
    logic cnt;
  } lock_pair_t;
endpackage

// File: rtl/mcv_lock_ctrl.sv
module mcv_lock_ctrl
  import mcv_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       soft_rst,
  input  lock_pair_t soft_set,
  input  lock_pair_t hard_set,
  output lock_pair_t soft_q,
  output lock_pair_t hard_q,
  output logic       cnt_locked,
  output logic       gpr_locked
);
  // soft level: software reset wins over a same-cycle set
  always_ff @(posedge clk) begin
    if (rst || soft_rst) begin
      soft_q <= '0;
    end else begin
      soft_q.cnt <= soft_q.cnt | soft_set.cnt;
      soft_q.gpr <= soft_q.gpr | soft_set.gpr;
    end
  end

  // hard level: only power-on reset clears
  always_ff @(posedge clk) begin
    if (rst) begin
      hard_q <= '0;
    end else begin
      hard_q.cnt <= hard_q.cnt | hard_set.cnt;
      hard_q.gpr <= hard_q.gpr | hard_set.gpr;
    end
  end

  assign cnt_locked = soft_q.cnt | hard_q.cnt;
  assign gpr_locked = soft_q.gpr | hard_q.gpr;
endmodule

// File: rtl/mcv_counter.sv
module mcv_counter
  import mcv_pkg::*;
#(
  parameter int CNT_LO_W = 32,
  parameter int CNT_HI_W = 16
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         locked,
  input  logic                         inc_req,
  input  logic                         era_we,
  input  logic [ERA_W-1:0]             era_wd,
  input  logic                         enable_set,
  output logic [CNT_LO_W+CNT_HI_W-1:0] count,
  output logic [ERA_W-1:0]             era,
  output logic                         en_valid,
  output logic                         rollover
);
  localparam int CNT_W = CNT_LO_W + CNT_HI_W;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic do_inc;
  logic wraps;
  assign do_inc = inc_req && en_valid && !locked;
  assign wraps  = do_inc && (count == CNT_MAX);

  always_ff @(posedge clk) begin
    if (rst) begin
      count    <= '0;
      rollover <= 1'b0;
    end else if (do_inc) begin
      count <= CNT_W'(count + 1'b1);
      if (wraps) rollover <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_valid <= 1'b0;
    end else if (wraps) begin
      en_valid <= 1'b0;
    end else if (enable_set && !locked && !rollover) begin
      en_valid <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      era <= '0;
    end else if (era_we && !locked) begin
      era <= era_wd;
    end
  end
endmodule

// File: rtl/mcv_gpr_bank.sv
module mcv_gpr_bank #(
  parameter int N_WORDS = 4,
  parameter int WORD_W  = 32,
  localparam int IDX_W  = (N_WORDS > 1) ? $clog2(N_WORDS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [IDX_W-1:0]  widx,
  input  logic [WORD_W-1:0] wd,
  input  logic [IDX_W-1:0]  ridx,
  output logic [WORD_W-1:0] rd
);
  logic [WORD_W-1:0] mem [N_WORDS];

  for (genvar i = 0; i < N_WORDS; i++) begin : g_word
    always_ff @(posedge clk) begin
      if (rst) begin
        mem[i] <= '0;
      end else if (we && (widx == IDX_W'(i))) begin
        mem[i] <= wd;
      end
    end
  end

  assign rd = mem[ridx];
endmodule

// File: rtl/mono_ctr_vault.sv
module mono_ctr_vault
  import mcv_pkg::*;
#(
  parameter int CNT_LO_W = 32,
  parameter int CNT_HI_W = 16,
  parameter int ADDR_W   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              soft_rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata
);
  localparam int CNT_W   = CNT_LO_W + CNT_HI_W;
  localparam int N_GPR   = 4;
  localparam int GPR_IW  = $clog2(N_GPR);

  lock_pair_t soft_q, hard_q, soft_set, hard_set;
  logic cnt_locked, gpr_locked;
  logic [CNT_W-1:0] cnt_value;
  logic [ERA_W-1:0] era_value;
  logic en_valid, rollover;
  logic [DATA_W-1:0] gpr_rd, hi_word, lo_word, rd_next;
  logic gpr_hit, gpr_we;

  assign gpr_hit = (addr[3:2] == GPR_ALIAS) || (addr[3:2] == GPR_PRIME);
  assign gpr_we  = wr_en && gpr_hit && !gpr_locked;

  always_comb begin
    soft_set     = '0;
    hard_set     = '0;
    soft_set.cnt = wr_en && (addr == A_SOFTLOCK) && wdata[B_CNT_LOCK];
    soft_set.gpr = wr_en && (addr == A_SOFTLOCK) && wdata[B_GPR_LOCK];
    hard_set.cnt = wr_en && (addr == A_HARDLOCK) && wdata[B_CNT_LOCK];
    hard_set.gpr = wr_en && (addr == A_HARDLOCK) && wdata[B_GPR_LOCK];
  end

  mcv_lock_ctrl u_locks (
    .clk        (clk),
    .rst        (rst),
    .soft_rst   (soft_rst),
    .soft_set   (soft_set),
    .hard_set   (hard_set),
    .soft_q     (soft_q),
    .hard_q     (hard_q),
    .cnt_locked (cnt_locked),
    .gpr_locked (gpr_locked)
  );

  mcv_counter #(.CNT_LO_W(CNT_LO_W), .CNT_HI_W(CNT_HI_W)) u_counter (
    .clk        (clk),
    .rst        (rst),
    .locked     (cnt_locked),
    .inc_req    (wr_en && (addr == A_CNT_LO)),
    .era_we     (wr_en && (addr == A_CNT_HI)),
    .era_wd     (wdata[31:16]),
    .enable_set (wr_en && (addr == A_CTRL) && wdata[B_ENABLE]),
    .count      (cnt_value),
    .era        (era_value),
    .en_valid   (en_valid),
    .rollover   (rollover)
  );

  mcv_gpr_bank #(.N_WORDS(N_GPR), .WORD_W(DATA_W)) u_gpr (
    .clk  (clk),
    .rst  (rst),
    .we   (gpr_we),
    .widx (addr[GPR_IW-1:0]),
    .wd   (wdata),
    .ridx (addr[GPR_IW-1:0]),
    .rd   (gpr_rd)
  );

  always_comb begin
    hi_word = '0;
    hi_word[CNT_HI_W-1:0] = cnt_value[CNT_W-1:CNT_LO_W];
    hi_word[31:16] = era_value;
    lo_word = '0;
    lo_word[CNT_LO_W-1:0] = cnt_value[CNT_LO_W-1:0];
  end

  always_comb begin
    rd_next = '0;
    if (gpr_hit) begin
      rd_next = gpr_rd;
    end else begin
      unique case (addr)
        A_SOFTLOCK: begin
          rd_next[B_CNT_LOCK] = soft_q.cnt;
          rd_next[B_GPR_LOCK] = soft_q.gpr;
        end
        A_HARDLOCK: begin
          rd_next[B_CNT_LOCK] = hard_q.cnt;
          rd_next[B_GPR_LOCK] = hard_q.gpr;
        end
        A_CTRL:   rd_next[B_ENABLE]   = en_valid;
        A_STATUS: rd_next[B_ROLLOVER] = rollover;
        A_CNT_HI: rd_next = hi_word;
        A_CNT_LO: rd_next = lo_word;
        default:  rd_next = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_en) begin
      rdata <= rd_next;
    end
  end
endmodule

// File: rtl/mcv_checker.sv
module mcv_checker #(
  parameter int CNT_W = 48
) (
  input logic             clk,
  input logic             rst,
  input logic             soft_rst,
  input logic [CNT_W-1:0] count,
  input logic             en_valid,
  input logic             rollover,
  input logic             cnt_locked,
  input logic             soft_cnt,
  input logic             hard_cnt,
  input logic             hard_gpr
);
  a_r2_step_one: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (count == $past(count)) || (count == CNT_W'($past(count) + 1'b1)));

  a_r3_disabled_hold: assert property (@(posedge clk) disable iff (rst)
    !en_valid |=> $stable(count));

  a_r4_locked_hold: assert property (@(posedge clk) disable iff (rst)
    cnt_locked |=> $stable(count));

  a_r6_soft_clear: assert property (@(posedge clk) disable iff (rst)
    soft_rst |=> !soft_cnt);

  a_r7_hard_sticky: assert property (@(posedge clk) disable iff (rst)
    (hard_cnt || hard_gpr) |=> (hard_cnt || !$past(hard_cnt)) && (hard_gpr || !$past(hard_gpr)));

  a_r9_roll_sticky: assert property (@(posedge clk) disable iff (rst)
    rollover |=> rollover && !en_valid);
endmodule

bind mono_ctr_vault mcv_checker #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .soft_rst   (soft_rst),
  .count      (cnt_value),
  .en_valid   (en_valid),
  .rollover   (rollover),
  .cnt_locked (cnt_locked),
  .soft_cnt   (soft_q.cnt),
  .hard_cnt   (hard_q.cnt),
  .hard_gpr   (hard_q.gpr)
);

// File: tb/mono_ctr_vault_tb.sv
module mono_ctr_vault_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        soft_rst = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata_big, rdata_small;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  mono_ctr_vault u_dut (
    .clk(clk), .rst(rst), .soft_rst(soft_rst), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata_big)
  );

  // narrow count (4 + 2 bits) on the same bus, so that wrap is reachable
  mono_ctr_vault #(.CNT_LO_W(4), .CNT_HI_W(2)) u_small (
    .clk(clk), .rst(rst), .soft_rst(soft_rst), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata_small)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] vb, output logic [31:0] vs);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    vb = rdata_big;
    vs = rdata_small;
  endtask

  task automatic por();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic incs(input int n);
    for (int i = 0; i < n; i++) wr(4'h5, 32'h0);
  endtask

  task automatic t_reset();
    logic [31:0] b, s;
    for (int a = 0; a < 16; a++) begin
      rd(4'(a), b, s);
      chk($sformatf("R1 reset addr %0d big", a), b, 32'h0);
      chk($sformatf("R1 reset addr %0d small", a), s, 32'h0);
    end
  endtask

  task automatic t_disabled();
    logic [31:0] b, s;
    wr(4'h5, 32'h1);
    rd(4'h5, b, s);
    chk("R3 no inc while disabled", b, 32'h0);
  endtask

  task automatic t_increment();
    logic [31:0] b, s;
    wr(4'h2, 32'h4);
    rd(4'h2, b, s);
    chk("R2 enable bit set", b, 32'h4);
    incs(3);
    rd(4'h5, b, s);
    chk("R2 three increments", b, 32'd3);
    wr(4'h5, 32'hFFFF_FFFF);
    rd(4'h5, b, s);
    chk("R2 data ignored, +1", b, 32'd4);
    chk("R11 registered read of low word", s, 32'd4);
  endtask

  task automatic t_era();
    logic [31:0] b, s;
    wr(4'h4, 32'hABCD_00FF);
    rd(4'h4, b, s);
    chk("R8 era loaded, count bits ignored", b, 32'hABCD_0000);
  endtask

  task automatic t_carry();
    logic [31:0] b, s;
    incs(12);
    rd(4'h5, b, s);
    chk("R2 big low word 16", b, 32'd16);
    chk("R2 small low part wrapped", s, 32'd0);
    rd(4'h4, b, s);
    chk("R2 small carry into high word", s, 32'hABCD_0001);
  endtask

  task automatic t_gpr();
    logic [31:0] b, s;
    wr(4'hD, 32'h0000_1111);
    rd(4'h9, b, s);
    chk("R10 primary write seen at alias", b, 32'h0000_1111);
    wr(4'hA, 32'h0000_2222);
    rd(4'hE, b, s);
    chk("R10 alias write seen at primary", b, 32'h0000_2222);
    wr(4'h0, 32'h20);
    wr(4'hD, 32'h0000_5555);
    rd(4'hD, b, s);
    chk("R5 soft gpr lock blocks write", b, 32'h0000_1111);
    rd(4'h0, b, s);
    chk("R5 soft gpr lock readback", b, 32'h20);
  endtask

  task automatic t_soft_cnt_lock();
    logic [31:0] b, s;
    wr(4'h0, 32'h10);
    wr(4'h5, 32'h0);
    rd(4'h5, b, s);
    chk("R4 soft lock blocks inc", b, 32'd16);
    wr(4'h4, 32'h1234_0000);
    rd(4'h4, b, s);
    chk("R4 soft lock blocks era write", b, 32'hABCD_0000);
    wr(4'h0, 32'h0);
    rd(4'h0, b, s);
    chk("R7 writing 0 keeps soft locks", b, 32'h30);
  endtask

  task automatic t_soft_reset();
    logic [31:0] b, s;
    @(negedge clk); soft_rst = 1'b1;
    @(negedge clk); soft_rst = 1'b0;
    rd(4'h0, b, s);
    chk("R6 soft locks cleared", b, 32'h0);
    rd(4'h5, b, s);
    chk("R6 count kept", b, 32'd16);
    rd(4'hD, b, s);
    chk("R6 gpr kept", b, 32'h0000_1111);
    rd(4'h4, b, s);
    chk("R6 era kept", b, 32'hABCD_0000);
    wr(4'hD, 32'h0000_5555);
    rd(4'h9, b, s);
    chk("R6 gpr writable again", b, 32'h0000_5555);
  endtask

  task automatic t_hard_lock();
    logic [31:0] b, s;
    wr(4'h1, 32'h30);
    wr(4'h1, 32'h0);
    @(negedge clk); soft_rst = 1'b1;
    @(negedge clk); soft_rst = 1'b0;
    rd(4'h1, b, s);
    chk("R7 hard lock survives 0 write and soft reset", b, 32'h30);
    wr(4'h5, 32'h0);
    rd(4'h5, b, s);
    chk("R4 hard lock blocks inc", b, 32'd16);
    wr(4'hC, 32'hDEAD_BEEF);
    rd(4'hC, b, s);
    chk("R5 hard gpr lock blocks write", b, 32'h0);
    por();
    rd(4'h1, b, s);
    chk("R7 power-on reset clears hard lock", b, 32'h0);
    rd(4'hD, b, s);
    chk("R1 gpr cleared by power-on reset", b, 32'h0);
  endtask

  task automatic t_rollover();
    logic [31:0] b, s;
    wr(4'h0, 32'h10);
    wr(4'h2, 32'h4);
    rd(4'h2, b, s);
    chk("R4 soft lock blocks enable set", b, 32'h0);
    @(negedge clk); soft_rst = 1'b1;
    @(negedge clk); soft_rst = 1'b0;
    wr(4'h2, 32'h4);
    incs(63);
    rd(4'h3, b, s);
    chk("R9 no rollover at all-ones", s, 32'h0);
    wr(4'h5, 32'h0);
    rd(4'h5, b, s);
    chk("R9 small count wrapped to 0", s, 32'h0);
    chk("R9 big count reads 64", b, 32'd64);
    rd(4'h3, b, s);
    chk("R9 rollover flag set", s, 32'h4);
    chk("R9 big has no rollover", b, 32'h0);
    rd(4'h2, b, s);
    chk("R9 enable dropped", s, 32'h0);
    chk("R9 big stays enabled", b, 32'h4);
    wr(4'h2, 32'h4);
    wr(4'h5, 32'h0);
    rd(4'h2, b, s);
    chk("R9 enable cannot be set again", s, 32'h0);
    rd(4'h5, b, s);
    chk("R9 increment ignored after wrap", s, 32'h0);
    rd(4'h4, b, s);
    chk("R9 high word wrapped", s, 32'h0);
  endtask

  task automatic t_unmapped();
    logic [31:0] b, s;
    wr(4'h6, 32'hFFFF_FFFF);
    rd(4'h6, b, s);
    chk("R11 unmapped 0x6 reads 0", b, 32'h0);
    rd(4'h7, b, s);
    chk("R11 unmapped 0x7 reads 0", b, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_disabled();
    t_increment();
    t_era();
    t_carry();
    t_gpr();
    t_soft_cnt_lock();
    t_soft_reset();
    t_hard_lock();
    t_rollover();
    t_unmapped();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule